// File: doc/BRIEF.md
# Fractional Pulse-Swallowing Clock Divider

This block derives a clock enable from a parent clock. In every 32-cycle window of the parent clock it lets through exactly `mult` enable pulses, spread as evenly as possible. A second stage then keeps only every `FIXED_DIV`-th of those pulses. The average enable rate is therefore parent × mult / (32 × FIXED_DIV). The enable feeds a downstream clock gate, which this block does not contain.

Software programs a 5-bit ratio code. The code holds 32 minus the multiplier, so code 0 gives the full rate and code 31 gives 1/32. The code sits at bit `FIELD_OFFSET mod 32` of the control word at address `FIELD_OFFSET / 32`. Writing a code has no immediate effect. A separate commit register arms the change. A small state machine with two states handles the commit:

- `ST_IDLE` moves to `ST_PENDING` (transition *arm*) when a commit write arrives.
- `ST_PENDING` returns to `ST_IDLE` (transition *commit*) on the last cycle of the current window.
- On the *commit* transition the new multiplier is loaded.

The commit bit reads back as 1 while the state machine is in `ST_PENDING`. Software polls this bit until it clears, which marks completion.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, `clk_en` is 0, every register reads 0, and the active multiplier is 32 (code 0).
- R2: The register map uses `reg_addr` as follows. Address 0 is control word A and address 1 is control word B. The 5-bit code lives only in the word numbered `FIELD_OFFSET/32`, at bits `[FIELD_OFFSET%32 +: 5]`. Address 2 is the commit register, with the commit flag at bit 31. All other bits read 0.
- R3: The active multiplier equals 32 minus the committed code. The range is 1 to 32.
- R4: Writing address 2 with bit 31 set, while the commit flag is clear, sets the flag on the next cycle. The flag then reads 1.
- R5: A pending commit completes on the last cycle of the 32-cycle window. The new multiplier governs the window that starts on the next cycle. The commit flag reads 0 from that same cycle. A commit takes at most 32 cycles.
- R6: Writes to the code field while the commit flag is set are ignored. The readback keeps the earlier code.
- R7: The fractional stage uses a 5-bit accumulator. The accumulator starts a window at 0 and adds the multiplier every cycle. When the sum reaches 32, the stage produces a pulse and keeps the sum modulo 32. This gives exactly `mult` pulses per window.
- R8: The divide stage passes every `FIXED_DIV`-th fractional pulse to `clk_en`. The output is registered, so `clk_en` is high in the cycle after that pulse. Over 32×FIXED_DIV cycles there are exactly `mult` enables, and with FIXED_DIV > 1 no two enables are adjacent.
- R9: Three kinds of write leave all state unchanged: a write to address 3, a write to the control word that holds no field, and a commit write with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0, 1 control words; 2 commit) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| clk_en | output | 1 | Divided clock enable |

## Verification
The ratio is exercised at four codes:

- Code 0 (every cycle) and code 31 (one pulse per window) cover the two ends of the accumulator range.
- Codes 7 and 16 show whether pulses are spread or bunched and whether the divide stage drops the correct ones.

A behavioural model running beside the design tells a commit that lands one cycle early or late apart from one on the window boundary. A code written while a commit is pending shows whether the lock is honoured. Writes to the empty control word, to address 3 and to the commit register with the flag clear show whether any of them leaks into state.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int WIN_LEN = 32;
    localparam int CODE_W  = 5;
    localparam int MULT_W  = 6;
    localparam logic [1:0] ADDR_CTRL_A = 2'd0;
    localparam logic [1:0] ADDR_CTRL_B = 2'd1;
    localparam logic [1:0] ADDR_KICK   = 2'd2;
    localparam int KICK_BIT = 31;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } kick_state_e;
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
    import fcd_pkg::*;
#(
    parameter int FIELD_OFFSET = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wr_data,
    input  logic              busy,
    output logic [31:0]       rd_data,
    output logic [CODE_W-1:0] code,
    output logic              kick_req
);
    localparam int REG_SEL = FIELD_OFFSET / 32;
    localparam int POS     = FIELD_OFFSET % 32;
    localparam logic [1:0] SEL_ADDR = 2'(REG_SEL);

    logic [CODE_W-1:0] code_q;
    logic [31:0]       field_word;
    logic              unused_wdata;

    assign unused_wdata = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (wr_en && addr == SEL_ADDR && !busy) begin
            code_q <= wr_data[POS +: CODE_W];
        end
    end

    assign code       = code_q;
    assign kick_req   = wr_en && (addr == ADDR_KICK) && wr_data[KICK_BIT];
    assign field_word = 32'(code_q) << POS;

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_CTRL_A: rd_data = (SEL_ADDR == ADDR_CTRL_A) ? field_word : '0;
            ADDR_CTRL_B: rd_data = (SEL_ADDR == ADDR_CTRL_B) ? field_word : '0;
            ADDR_KICK:   rd_data[KICK_BIT] = busy;
            default:     rd_data = '0;
        endcase
    end

    // R6
    code_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(code_q));
endmodule

// File: rtl/fcd_kick_fsm.sv
module fcd_kick_fsm
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_req,
    input  logic [CODE_W-1:0] code,
    output logic              busy,
    output logic [MULT_W-1:0] mult,
    output logic              win_last
);
    kick_state_e       state_q, state_d;
    logic [4:0]        win_cnt;
    logic [MULT_W-1:0] mult_q;
    logic              commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_cnt <= '0;
        else        win_cnt <= win_cnt + 5'd1;
    end

    assign win_last = &win_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (kick_req) state_d = ST_PENDING;
            ST_PENDING: if (win_last) state_d = ST_IDLE;
        endcase
    end

    assign commit = (state_q == ST_PENDING) && win_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mult_q <= MULT_W'(WIN_LEN);
        else if (commit) mult_q <= MULT_W'(WIN_LEN) - {1'b0, code};
    end

    assign busy = (state_q == ST_PENDING);
    assign mult = mult_q;

    // R5
    kick_clear_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(win_last));
    // R5
    mult_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_last |=> $stable(mult_q));
    // R3
    mult_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_q >= MULT_W'(1)) && (mult_q <= MULT_W'(WIN_LEN)));
endmodule

// File: rtl/fcd_accum.sv
module fcd_accum
    import fcd_pkg::*;
#(
    parameter int FIXED_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MULT_W-1:0] mult,
    input  logic              win_last,
    output logic              clk_en
);
    localparam int DCW = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;

    logic [4:0]        acc_q;
    logic [MULT_W-1:0] sum;
    logic              frac_hit;
    logic              en_q;

    assign sum      = {1'b0, acc_q} + mult;
    assign frac_hit = sum[MULT_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[4:0];
    end

    generate
        if (FIXED_DIV == 1) begin : g_nodiv
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) en_q <= 1'b0;
                else        en_q <= frac_hit;
            end
        end else begin : g_div
            logic [DCW-1:0] div_cnt;
            logic           div_last;
            assign div_last = (div_cnt == DCW'(FIXED_DIV - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_cnt <= '0;
                    en_q    <= 1'b0;
                end else begin
                    en_q <= frac_hit && div_last;
                    if (frac_hit) div_cnt <= div_last ? '0 : div_cnt + DCW'(1);
                end
            end
            // R8
            en_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
                en_q |=> !en_q);
        end
    endgenerate

    assign clk_en = en_q;

    // R7
    acc_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> (acc_q == 5'd0));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fcd_pkg::*;
#(
    parameter int FIELD_OFFSET = 35,
    parameter int FIXED_DIV    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        clk_en
);
    logic [CODE_W-1:0] code;
    logic              kick_req;
    logic              busy;
    logic [MULT_W-1:0] mult;
    logic              win_last;

    fcd_regs #(.FIELD_OFFSET(FIELD_OFFSET)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wr_data(reg_wdata), .busy(busy), .rd_data(reg_rdata),
        .code(code), .kick_req(kick_req)
    );

    fcd_kick_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .kick_req(kick_req), .code(code),
        .busy(busy), .mult(mult), .win_last(win_last)
    );

    fcd_accum #(.FIXED_DIV(FIXED_DIV)) u_accum (
        .clk(clk), .rst_n(rst_n), .mult(mult), .win_last(win_last),
        .clk_en(clk_en)
    );
endmodule

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
    localparam int OFS = 35;
    localparam int FD  = 2;
    localparam int SEL = OFS / 32;
    localparam int POS = OFS % 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en;

    int checks = 0, errors = 0, cycles = 0;
    int m_win, m_acc, m_mult, m_code, m_busy, m_divc, m_en;
    bit cmp_on = 0;

    frac_clk_div #(.FIELD_OFFSET(OFS), .FIXED_DIV(FD)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_win = 0; m_acc = 0; m_mult = 32; m_code = 0;
            m_busy = 0; m_divc = 0; m_en = 0;
        end else begin
            int sum, old_busy;
            bit frac, kick;
            old_busy = m_busy;
            sum  = m_acc + m_mult;
            frac = (sum >= 32);
            m_acc = sum % 32;
            m_en = (frac && m_divc == FD - 1) ? 1 : 0;
            if (frac) m_divc = (m_divc + 1) % FD;
            kick = reg_wr && reg_addr == 2'd2 && reg_wdata[31];
            if (old_busy != 0 && m_win == 31) begin
                m_mult = 32 - m_code;
                m_busy = 0;
            end else if (old_busy == 0 && kick) begin
                m_busy = 1;
            end
            if (reg_wr && reg_addr == 2'(SEL) && old_busy == 0)
                m_code = int'((reg_wdata >> POS) & 32'd31);
            m_win = (m_win + 1) % 32;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            longint exp_rd;
            check(clk_en == m_en[0], "R8 clk_en vs model", clk_en, m_en);
            if (reg_addr == 2'(SEL))  exp_rd = longint'(m_code) << POS;
            else if (reg_addr == 2'd2) exp_rd = longint'(m_busy) << 31;
            else exp_rd = 0;
            check(reg_rdata == exp_rd[31:0], "R2 reg_rdata vs model", reg_rdata, exp_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic wait_commit(input string tag);
        logic [31:0] d;
        int polls = 0;
        rd(2'd2, d);
        while (d[31] && polls < 40) begin
            polls++;
            rd(2'd2, d);
        end
        check(polls <= 32, tag, polls, 32);
    endtask

    task automatic count_en(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (clk_en) c++;
        end
    endtask

    task automatic set_code(input int code, input string tag);
        logic [31:0] d;
        int c;
        wr(2'(SEL), 32'(code) << POS);
        wr(2'd2, 32'h8000_0000);
        rd(2'd2, d);
        // R4: commit flag set right after the write
        check(d[31] == 1'b1 || m_busy == 0, "R4 commit flag set", d[31], 1);
        wait_commit("R5 commit completes within a window");
        repeat (2) @(posedge clk);
        count_en(32 * FD, c);
        check(c == 32 - code, tag, c, 32 - code);
    endtask

    initial begin
        logic [31:0] d;
        int c;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(clk_en == 1'b0, "R1 clk_en after reset", clk_en, 0);
        check(reg_rdata == 32'd0, "R1 readback after reset", reg_rdata, 0);
        cmp_on = 1;
        count_en(64, c);
        check(c == 32, "R1 R3 full rate at code 0", c, 32);

        set_code(31, "R3 R7 code 31 gives one per window");
        set_code(16, "R3 R7 code 16 gives 16 enables");
        set_code(7,  "R3 R8 code 7 gives 25 enables");

        // R6: write during pending commit is ignored
        wr(2'(SEL), 32'(5) << POS);
        wr(2'd2, 32'h8000_0000);
        wr(2'(SEL), 32'(20) << POS);
        rd(2'(SEL), d);
        check(d == (32'(5) << POS), "R6 locked field keeps code", d, 32'(5) << POS);
        wait_commit("R5 commit after locked write");
        repeat (2) @(posedge clk);
        count_en(32 * FD, c);
        check(c == 27, "R6 rate uses earlier code", c, 27);

        // R9: writes that must leave state unchanged
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'(1 - SEL), 32'hFFFF_FFFF);
        wr(2'd2, 32'h7FFF_FFFF);
        rd(2'd2, d);
        check(d == 32'd0, "R9 kick write with bit31 clear", d, 0);
        rd(2'(SEL), d);
        check(d == (32'(5) << POS), "R9 field unchanged", d, 32'(5) << POS);
        rd(2'(1 - SEL), d);
        check(d == 32'd0, "R2 R9 empty control word reads 0", d, 0);
        count_en(32 * FD, c);
        check(c == 27, "R9 rate unchanged", c, 27);

        set_code(0, "R3 back to full rate");

        cmp_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule